// File: doc/BRIEF.md
# Mailbox Unread-Message Overrun Tracker

This block keeps three per-mailbox flag sets for a message controller with 32 mailboxes. The first holds receive-pending flags for data frames. The second holds pending flags for remote frames. The third holds overrun flags. An overrun flag records that a new frame arrived in a mailbox while an earlier arrival there was still unacknowledged. Each flag is set by a one-cycle receive-complete strobe, which carries a mailbox index and a frame type. Software acknowledges a flag by writing a one to it.

A per-mailbox direction vector marks transmit mailboxes. A reception aimed at one of these leaves every flag untouched. Software reaches all three flag sets through a 16-bit register port. The port takes a 2-bit register select and a half-select, and read data is returned combinationally. A single summary output is high while any overrun flag is set, and can serve as an interrupt request.

Top module: `mbx_overrun_tracker`

## Requirements
- R1: After reset all receive-pending, remote-pending and overrun flags are 0 and `ovr_irq` is low.
- R2: A reception strobe with `rx_remote`=0 sets the receive-pending flag of mailbox `rx_idx`. With `rx_remote`=1 it sets that mailbox's remote-pending flag instead. The result is readable after the next clock edge.
- R3: A reception into a receive mailbox sets that mailbox's overrun flag when its receive-pending flag or its remote-pending flag was already set before the edge at which the reception is taken.
- R4: Writing a register clears exactly the flags at bit positions where the write data holds 1. Bits written with 0 keep their value. This applies to all three flag registers.
- R5: A reception into a mailbox whose `mbx_is_tx` bit is 1 changes no flag, and never sets an overrun flag.
- R6: `reg_sel` 0 selects the overrun register, 1 the receive-pending register and 2 the remote-pending register. `reg_sel` 3 reads as 0 and writes to it are ignored. `reg_half`=0 maps mailboxes 15..0 and `reg_half`=1 maps mailboxes 31..16, with mailbox 16*h+n on bit n.
- R7: When a software clear and a hardware set hit the same flag in the same cycle, the flag ends up set.
- R8: `ovr_irq` is high exactly while at least one overrun flag is set.
- R9: The first reception into a mailbox with neither pending flag set does not set its overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | 1 | One-cycle strobe: a frame has been stored |
| rx_idx | input | 5 | Mailbox index of the stored frame |
| rx_remote | input | 1 | 1 = remote frame, 0 = data frame |
| mbx_is_tx | input | 32 | Per-mailbox direction, 1 = transmit mailbox |
| reg_wr | input | 1 | Register write strobe (write-one-to-clear) |
| reg_sel | input | 2 | Register select: 0 overrun, 1 receive-pending, 2 remote-pending |
| reg_half | input | 1 | Half select: 0 mailboxes 15..0, 1 mailboxes 31..16 |
| reg_wdata | input | 16 | Write data, ones mark flags to clear |
| reg_rdata | output | 16 | Selected register half, combinational |
| ovr_irq | output | 1 | High while any overrun flag is set |

## Verification
The bench uses the default parameters: 32 mailboxes and 16-bit registers. With these values both halves of every register are in play. It marks mailboxes 0 and 31 as transmit mailboxes, which puts the direction filter at both ends of the index range, one in each half. The bench covers several cases: an overrun raised by a remote-pending hit, clears with every mix of 0 and 1 bits, and the same-cycle clear-versus-set conflict on both pending and overrun flags. It also checks a re-reception after an acknowledge, which must not raise an overrun.

// File: rtl/mbx_pkg.sv
// Shared definitions for the mailbox flag tracker.
// Assumes register select codes are fixed by the software view.
package mbx_pkg;
    typedef enum logic [1:0] {
        RSEL_OVR  = 2'd0,
        RSEL_RXP  = 2'd1,
        RSEL_RMP  = 2'd2,
        RSEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbx_flag_bank.sv
// Bank of sticky flags: hardware sets, software clears by writing ones.
// Assumes set and clear vectors are single-cycle pulses; a set beats a
// clear on the same bit.
module mbx_flag_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    // Update flags: clear selected bits, then apply sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    AST_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags_q & $past(flags_q) & ~$past(clr_i)) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_i) & ~flags_q) == '0)); // R7
endmodule

// File: rtl/mbx_event_decode.sv
// Turns a reception strobe into per-mailbox set vectors for the
// receive-pending, remote-pending and overrun banks.
// Assumes pending inputs are the registered state before this edge.
module mbx_event_decode #(
    parameter int N_MBX = 32,
    localparam int IDX_W = $clog2(N_MBX)
) (
    input  logic             rx_done,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic             rx_remote,
    input  logic [N_MBX-1:0] is_tx,
    input  logic [N_MBX-1:0] rxp,
    input  logic [N_MBX-1:0] rmp,
    output logic [N_MBX-1:0] rxp_set,
    output logic [N_MBX-1:0] rmp_set,
    output logic [N_MBX-1:0] ovr_set
);
    logic [N_MBX-1:0] hit;

    // One-hot target mailbox, blank for transmit mailboxes or bad index.
    always_comb begin
        hit = '0;
        if (rx_done && (int'(rx_idx) < N_MBX) && !is_tx[rx_idx])
            hit[rx_idx] = 1'b1;
    end

    // Route the hit by frame type and flag overrun on an occupied mailbox.
    always_comb begin
        rxp_set = rx_remote ? '0 : hit;
        rmp_set = rx_remote ? hit : '0;
        ovr_set = hit & (rxp | rmp);
    end
endmodule

// File: rtl/mbx_reg_port.sv
// Software register port: write-one-to-clear decode and read mux over the
// three flag vectors, each split into REG_W-bit halves.
// Assumes N_MBX is a multiple of REG_W; reads have no wait states.
module mbx_reg_port
    import mbx_pkg::*;
#(
    parameter int N_MBX  = 32,
    parameter int REG_W  = 16,
    localparam int N_HALF = N_MBX / REG_W,
    localparam int HSEL_W = (N_HALF > 1) ? $clog2(N_HALF) : 1
) (
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [HSEL_W-1:0] half,
    input  logic [REG_W-1:0]  wdata,
    input  logic [N_MBX-1:0]  ovr,
    input  logic [N_MBX-1:0]  rxp,
    input  logic [N_MBX-1:0]  rmp,
    output logic [N_MBX-1:0]  clr_ovr,
    output logic [N_MBX-1:0]  clr_rxp,
    output logic [N_MBX-1:0]  clr_rmp,
    output logic [REG_W-1:0]  rdata
);
    logic [N_MBX-1:0] wmask;
    logic [N_MBX-1:0] rsrc;

    // Place write data over the addressed half only.
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        assign wmask[h*REG_W +: REG_W] =
            (wr_en && (int'(half) == h)) ? wdata : '0;
    end

    // Steer the clear mask to the selected register.
    always_comb begin
        clr_ovr = (reg_sel_e'(sel) == RSEL_OVR) ? wmask : '0;
        clr_rxp = (reg_sel_e'(sel) == RSEL_RXP) ? wmask : '0;
        clr_rmp = (reg_sel_e'(sel) == RSEL_RMP) ? wmask : '0;
    end

    // Select the source register and then the half for read-back.
    always_comb begin
        case (reg_sel_e'(sel))
            RSEL_OVR: rsrc = ovr;
            RSEL_RXP: rsrc = rxp;
            RSEL_RMP: rsrc = rmp;
            default:  rsrc = '0;
        endcase
        rdata = '0;
        for (int h = 0; h < N_HALF; h++)
            if (int'(half) == h) rdata = rsrc[h*REG_W +: REG_W];
    end
endmodule

// File: rtl/mbx_overrun_tracker.sv
// Top of the mailbox flag tracker: receive-pending, remote-pending and
// unread-message overrun flags for N_MBX mailboxes, software access
// through a write-one-to-clear register port, and an overrun summary.
// Assumes rx_done is a single-cycle strobe from the frame storage logic.
module mbx_overrun_tracker #(
    parameter int N_MBX = 32,
    parameter int REG_W = 16,
    localparam int IDX_W  = $clog2(N_MBX),
    localparam int N_HALF = N_MBX / REG_W,
    localparam int HSEL_W = (N_HALF > 1) ? $clog2(N_HALF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [IDX_W-1:0]  rx_idx,
    input  logic              rx_remote,
    input  logic [N_MBX-1:0]  mbx_is_tx,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [HSEL_W-1:0] reg_half,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ovr_irq
);
    logic [N_MBX-1:0] rxp, rmp, ovr;
    logic [N_MBX-1:0] rxp_set, rmp_set, ovr_set;
    logic [N_MBX-1:0] clr_rxp, clr_rmp, clr_ovr;

    mbx_event_decode #(.N_MBX(N_MBX)) u_dec (
        .rx_done(rx_done), .rx_idx(rx_idx), .rx_remote(rx_remote),
        .is_tx(mbx_is_tx), .rxp(rxp), .rmp(rmp),
        .rxp_set(rxp_set), .rmp_set(rmp_set), .ovr_set(ovr_set)
    );

    mbx_reg_port #(.N_MBX(N_MBX), .REG_W(REG_W)) u_port (
        .wr_en(reg_wr), .sel(reg_sel), .half(reg_half), .wdata(reg_wdata),
        .ovr(ovr), .rxp(rxp), .rmp(rmp),
        .clr_ovr(clr_ovr), .clr_rxp(clr_rxp), .clr_rmp(clr_rmp),
        .rdata(reg_rdata)
    );

    mbx_flag_bank #(.W(N_MBX)) u_rxp (
        .clk(clk), .rst_n(rst_n), .set_i(rxp_set), .clr_i(clr_rxp), .flags_o(rxp));
    mbx_flag_bank #(.W(N_MBX)) u_rmp (
        .clk(clk), .rst_n(rst_n), .set_i(rmp_set), .clr_i(clr_rmp), .flags_o(rmp));
    mbx_flag_bank #(.W(N_MBX)) u_ovr (
        .clk(clk), .rst_n(rst_n), .set_i(ovr_set), .clr_i(clr_ovr), .flags_o(ovr));

    // Summary request for the interrupt controller.
    assign ovr_irq = |ovr;

    AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (((ovr & ~$past(ovr)) & ~($past(rxp) | $past(rmp))) == '0)); // R3
    AST_OVR_NEVER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (((ovr & ~$past(ovr)) & $past(mbx_is_tx)) == '0)); // R5
    AST_PENDING_NEVER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        ((((rxp & ~$past(rxp)) | (rmp & ~$past(rmp))) & $past(mbx_is_tx)) == '0)); // R5
    AST_IRQ_RISE_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_irq) |-> $past(rx_done)); // R8
endmodule

// File: tb/tb_mbx_overrun_tracker.sv
module tb_mbx_overrun_tracker;
    localparam int N_MBX = 32;
    localparam int REG_W = 16;
    localparam logic [1:0] K_RX = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_IRQ = 2'd3;
    localparam logic [1:0] S_OVR = 2'd0, S_RXP = 2'd1, S_RMP = 2'd2, S_NONE = 2'd3;
    // {kind[26:25], idx[24:20], remote[19], sel[18:17], half[16], data[15:0]}
    localparam int NV = 44;
    localparam logic [26:0] VEC [NV] = '{
        {K_RX, 5'd3,  1'b0, S_OVR, 1'b0, 16'h0000},   // R2 data frame mbx3
        {K_RD, 5'd0,  1'b0, S_RXP, 1'b0, 16'h0008},   // R2
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R9 first arrival
        {K_RX, 5'd3,  1'b0, S_OVR, 1'b0, 16'h0000},   // R3 second arrival
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0008},   // R3
        {K_IRQ,5'd0,  1'b0, S_OVR, 1'b0, 16'h0001},   // R8
        {K_RX, 5'd20, 1'b1, S_OVR, 1'b0, 16'h0000},   // R2 remote mbx20
        {K_RD, 5'd0,  1'b0, S_RMP, 1'b1, 16'h0010},   // R2 R6 upper half
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b1, 16'h0000},   // R9
        {K_RX, 5'd20, 1'b0, S_OVR, 1'b0, 16'h0000},   // R3 hit on remote-pending
        {K_RD, 5'd0,  1'b0, S_RXP, 1'b1, 16'h0010},   // R2
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b1, 16'h0010},   // R3
        {K_RX, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R5 tx mbx0
        {K_RX, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R5
        {K_RD, 5'd0,  1'b0, S_RXP, 1'b0, 16'h0008},   // R5
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0008},   // R5
        {K_RX, 5'd31, 1'b1, S_OVR, 1'b0, 16'h0000},   // R5 tx mbx31
        {K_RX, 5'd31, 1'b1, S_OVR, 1'b0, 16'h0000},   // R5
        {K_RD, 5'd0,  1'b0, S_RMP, 1'b1, 16'h0010},   // R5
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b1, 16'h0010},   // R5
        {K_WR, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R4 zeros
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0008},   // R4
        {K_WR, 5'd0,  1'b0, S_OVR, 1'b0, 16'hFFF7},   // R4 ones elsewhere
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0008},   // R4
        {K_WR, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0008},   // R4 clear bit3
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R4
        {K_IRQ,5'd0,  1'b0, S_OVR, 1'b0, 16'h0001},   // R8 mbx20 still set
        {K_WR, 5'd0,  1'b0, S_OVR, 1'b1, 16'h0010},   // R4 R6
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b1, 16'h0000},   // R4
        {K_IRQ,5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R8
        {K_WR, 5'd0,  1'b0, S_NONE,1'b0, 16'hFFFF},   // R6 unused select
        {K_RD, 5'd0,  1'b0, S_NONE,1'b0, 16'h0000},   // R6
        {K_RD, 5'd0,  1'b0, S_NONE,1'b1, 16'h0000},   // R6
        {K_RD, 5'd0,  1'b0, S_RXP, 1'b0, 16'h0008},   // R6 write ignored
        {K_WR, 5'd0,  1'b0, S_RXP, 1'b0, 16'h0008},   // R4 acknowledge
        {K_RD, 5'd0,  1'b0, S_RXP, 1'b0, 16'h0000},   // R4
        {K_RX, 5'd3,  1'b0, S_OVR, 1'b0, 16'h0000},   // R9 after acknowledge
        {K_RD, 5'd0,  1'b0, S_RXP, 1'b0, 16'h0008},   // R2
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b0, 16'h0000},   // R9
        {K_WR, 5'd0,  1'b0, S_RMP, 1'b1, 16'h0010},   // R4
        {K_RD, 5'd0,  1'b0, S_RMP, 1'b1, 16'h0000},   // R4
        {K_WR, 5'd0,  1'b0, S_RXP, 1'b1, 16'h0010},   // R4
        {K_RX, 5'd20, 1'b0, S_OVR, 1'b0, 16'h0000},   // R9
        {K_RD, 5'd0,  1'b0, S_OVR, 1'b1, 16'h0000}    // R9
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_done = 1'b0, rx_remote = 1'b0, reg_wr = 1'b0, reg_half = 1'b0;
    logic [4:0] rx_idx = '0;
    logic [1:0] reg_sel = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [31:0] mbx_is_tx = 32'h8000_0001;
    logic ovr_irq;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbx_overrun_tracker #(.N_MBX(N_MBX), .REG_W(REG_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_idx(rx_idx),
        .rx_remote(rx_remote), .mbx_is_tx(mbx_is_tx), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_half(reg_half), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovr_irq(ovr_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read a register half combinationally, away from the edge.
    task automatic rd(input string req, input logic [1:0] s, input logic h, input logic [15:0] exp);
        @(negedge clk);
        reg_sel = s; reg_half = h;
        #1 check(req, reg_rdata, exp);
    endtask

    // Drive one cycle of reception and/or write, release after the edge.
    task automatic cyc(input logic rx, input logic [4:0] idx, input logic rem,
                       input logic wr, input logic [1:0] s, input logic h, input logic [15:0] d);
        @(negedge clk);
        rx_done = rx; rx_idx = idx; rx_remote = rem;
        reg_wr = wr; reg_sel = s; reg_half = h; reg_wdata = d;
        @(negedge clk);
        rx_done = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic check_all_zero(input string req);
        for (int s = 0; s < 3; s++)
            for (int h = 0; h < 2; h++)
                rd(req, s[1:0], h[0], 16'h0000);
        check(req, {15'd0, ovr_irq}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all_zero("R1");
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            case (v[26:25])
                K_RX:  cyc(1'b1, v[24:20], v[19], 1'b0, 2'd0, 1'b0, 16'h0);
                K_WR:  cyc(1'b0, 5'd0, 1'b0, 1'b1, v[18:17], v[16], v[15:0]);
                K_RD:  rd($sformatf("vec%0d R2-R9", i), v[18:17], v[16], v[15:0]);
                default: begin
                    @(negedge clk);
                    check($sformatf("vec%0d R8", i), {15'd0, ovr_irq}, v[15:0]);
                end
            endcase
        end
        // R7: clear and set on the same overrun bit (bit3 idle, rxp3 pending)
        cyc(1'b1, 5'd3, 1'b0, 1'b1, S_OVR, 1'b0, 16'h0008);
        rd("R7 overrun set beats clear", S_OVR, 1'b0, 16'h0008);
        cyc(1'b1, 5'd3, 1'b0, 1'b1, S_OVR, 1'b0, 16'h0008);
        rd("R7 overrun stays set", S_OVR, 1'b0, 16'h0008);
        // R7: pending clear of mbx3 alongside a set of mbx5
        cyc(1'b1, 5'd5, 1'b0, 1'b1, S_RXP, 1'b0, 16'h0008);
        rd("R7 pending mixed", S_RXP, 1'b0, 16'h0020);
        // R7 R3: same-bit pending clear and set; overrun uses the old state
        cyc(1'b1, 5'd5, 1'b0, 1'b1, S_RXP, 1'b0, 16'h0020);
        rd("R7 pending set beats clear", S_RXP, 1'b0, 16'h0020);
        rd("R3 overrun from pre-edge pending", S_OVR, 1'b0, 16'h0028);
        @(negedge clk);
        check("R8 irq high", {15'd0, ovr_irq}, 16'h0001);
        // R1: reset in the middle of activity
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_all_zero("R1 after reset");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule